// File: doc/BRIEF.md
# Synchronous Serial Word Receiver (Clock Master)

This block drives the clock of a synchronous serial link and reads data words from a remote sender over a single data line. No start or stop bits frame a word. The receiver opens a transfer by pulling its clock low, once it is enabled and the previous pause has fully run out. It then toggles the clock at a rate set by an integer divider of the system clock. It shifts in one data bit, MSB first, at every later falling edge until the programmed word length has been received. After the final rising edge, the clock rests high for a programmed pause time.

During that pause the block watches the data line. The sender must pull the line low inside a window. The window opens a guard time after the final rising edge, equal to twice the data delay count, and closes at the transfer timeout. The sender must also release the line high by the last cycle of the pause. A violation of either rule sets a sticky error flag and drops the word. A clean word is delivered at the end of its pause as a one-cycle valid pulse. The word is right-aligned on a 32-bit bus. All times are programmed as counts of system clock cycles.

Top module: `ssi_rx_master`

## Requirements
- R1: The serial clock output is high after reset, while idle and throughout each pause period.
- R2: The effective word length N is the programmed length clamped to the range 3..32. A transfer has N+1 falling edges. The first falling edge only opens the transfer, and the next N falling edges each sample one data bit, first bit received becoming the MSB of the word.
- R3: Each low and each high clock phase lasts H system cycles, where H is the half-period divider (0 is treated as 1). From the first falling edge to the final rising edge there are exactly (2N+1)*H cycles.
- R4: A delivered word sits in bits N-1..0 of the data output, and all bits from N upward are zero.
- R5: Counting g = 0 on the first system cycle after the final rising edge, a high data line at any cycle with 2*D <= g < T (D = data delay count, T = timeout count) is a timing error.
- R6: A low data line on the last pause cycle, g = P-1 (P = pause count, 0 treated as 1), is a timing error.
- R7: The error flag is set one cycle after a timing error. It stays set until the clear input is pulsed, and a new error in the same cycle as the clear wins.
- R8: A word with no timing error produces exactly one valid pulse, P cycles after the final rising edge. A word with a timing error produces no valid pulse.
- R9: No transfer starts while enable is low. With enable held high, the next first falling edge comes P+1 cycles after the final rising edge of the previous word.
- R10: A high data line at cycles g < 2*D is not an error, so the sender may keep the line high during its delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows new transfers to start |
| word_len | input | 6 | Programmed word length in bits (clamped to 3..32) |
| half_div | input | 16 | Serial clock half period in system cycles |
| pause_cyc | input | 32 | Pause time in system cycles |
| tmo_cyc | input | 32 | Transfer timeout in system cycles |
| dly_cyc | input | 16 | Sender data delay in system cycles |
| sdata_i | input | 1 | Serial data from the sender |
| err_clr | input | 1 | Clears the sticky error flag (status read) |
| sclk_o | output | 1 | Generated serial clock |
| word_vld | output | 1 | One-cycle pulse marking a clean received word |
| word_data | output | 32 | Received word, right-aligned |
| err_flag | output | 1 | Sticky timing error flag |

## Verification
The bench models the sender from the clock it sees. It measures the span of each word and the gap to the valid pulse, so a divider that counts H+1 phases, or an extra or missing falling edge, shows up as a wrong span. Words of 3 and 32 bits and out-of-range lengths show whether the clamp works and whether stale upper bits leak into the output. The timing windows are probed one cycle either side of each edge. A sender high one cycle past the guard time must fail while one cycle less passes, and a line still low on the last pause cycle must fail. A checker with an off-by-one window would accept a bad word or reject a good one. The sticky flag is shown to survive a later clean word and to clear only on the clear pulse.

// File: rtl/ssi_rx_pkg.sv
package ssi_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_HIGH  = 2'd2,
    ST_PAUSE = 2'd3
  } rx_state_e;
endpackage

// File: rtl/ssi_rx_baud.sv
module ssi_rx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim  = (half_div == '0) ? DIV_W'(1) : half_div;
    tick = run && (cnt_q == lim - DIV_W'(1));
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < lim)); // R3
endmodule

// File: rtl/ssi_rx_shift.sv
module ssi_rx_shift #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift,
  input  logic              din,
  input  logic [LEN_W-1:0]  len_eff,
  output logic [DATA_W-1:0] data,
  output logic              full
);
  logic [DATA_W-1:0] sr_q, sr_d;
  logic [LEN_W-1:0]  bit_q, bit_d;
  logic              upd;

  always_comb begin
    upd   = clear || shift;
    sr_d  = sr_q;
    bit_d = bit_q;
    if (clear) begin
      sr_d  = '0;
      bit_d = '0;
    end else if (shift) begin
      sr_d  = {sr_q[DATA_W-2:0], din};
      bit_d = bit_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      bit_q <= '0;
    end else if (upd) begin
      sr_q  <= sr_d;
      bit_q <= bit_d;
    end
  end

  assign data = sr_q;
  assign full = (bit_q == len_eff);

  AST_BITS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= len_eff); // R2
  AST_NO_SHIFT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !full); // R2
endmodule

// File: rtl/ssi_rx_gap.sv
module ssi_rx_gap #(
  parameter int CNT_W = 32,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic             sdata,
  input  logic [CNT_W-1:0] pause_cyc,
  input  logic [CNT_W-1:0] tmo_cyc,
  input  logic [DLY_W-1:0] dly_cyc,
  output logic             done,
  output logic             low_err,
  output logic             high_err
);
  localparam int PAD_W = CNT_W - DLY_W;

  logic [CNT_W-1:0] gap_q, gap_d, pause_last;
  logic [CNT_W:0]   win_start;
  logic             upd;

  always_comb begin
    win_start  = {{PAD_W{1'b0}}, dly_cyc, 1'b0};
    pause_last = (pause_cyc == '0) ? '0 : pause_cyc - CNT_W'(1);
    done       = active && (gap_q >= pause_last);
    low_err    = active && sdata && ({1'b0, gap_q} >= win_start) && (gap_q < tmo_cyc);
    high_err   = done && !sdata;
    upd        = clear || (active && (gap_q != '1));
    gap_d      = clear ? '0 : gap_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   gap_q <= '0;
    else if (upd) gap_q <= gap_d;
  end

  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_GAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (gap_q == '0)); // R5
endmodule

// File: rtl/ssi_rx_master.sv
module ssi_rx_master
  import ssi_rx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 16,
  parameter int CNT_W   = 32,
  parameter int DLY_W   = 16,
  parameter int MIN_LEN = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [$clog2(DATA_W+1)-1:0] word_len,
  input  logic [DIV_W-1:0]            half_div,
  input  logic [CNT_W-1:0]            pause_cyc,
  input  logic [CNT_W-1:0]            tmo_cyc,
  input  logic [DLY_W-1:0]            dly_cyc,
  input  logic                        sdata_i,
  input  logic                        err_clr,
  output logic                        sclk_o,
  output logic                        word_vld,
  output logic [DATA_W-1:0]           word_data,
  output logic                        err_flag
);
  localparam int LEN_W = $clog2(DATA_W + 1);

  rx_state_e         st_q, st_d;
  logic              sclk_q, sclk_d;
  logic [LEN_W-1:0]  len_eff;
  logic              tick, run, full;
  logic              shift_clr, shift_en;
  logic              gap_clr, gap_act, done, low_err, high_err, any_err;
  logic [DATA_W-1:0] shreg;
  logic              werr_q, werr_d;
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] data_q;
  logic              err_q, err_d;

  always_comb begin
    if (word_len < LEN_W'(MIN_LEN))     len_eff = LEN_W'(MIN_LEN);
    else if (word_len > LEN_W'(DATA_W)) len_eff = LEN_W'(DATA_W);
    else                                len_eff = word_len;
  end

  assign run     = (st_q == ST_LOW) || (st_q == ST_HIGH);
  assign gap_act = (st_q == ST_PAUSE);
  assign any_err = low_err || high_err;

  ssi_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_div), .tick(tick)
  );

  ssi_rx_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(shift_clr), .shift(shift_en),
    .din(sdata_i), .len_eff(len_eff), .data(shreg), .full(full)
  );

  ssi_rx_gap #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .clear(gap_clr), .active(gap_act),
    .sdata(sdata_i), .pause_cyc(pause_cyc), .tmo_cyc(tmo_cyc),
    .dly_cyc(dly_cyc), .done(done), .low_err(low_err), .high_err(high_err)
  );

  // next-state logic of the transfer sequencer
  always_comb begin
    st_d      = st_q;
    sclk_d    = sclk_q;
    shift_clr = 1'b0;
    shift_en  = 1'b0;
    gap_clr   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (en) begin
        st_d      = ST_LOW;
        sclk_d    = 1'b0;
        shift_clr = 1'b1;
      end
      ST_LOW: if (tick) begin
        sclk_d = 1'b1;
        if (full) begin
          st_d    = ST_PAUSE;
          gap_clr = 1'b1;
        end else begin
          st_d = ST_HIGH;
        end
      end
      ST_HIGH: if (tick) begin
        sclk_d   = 1'b0;
        shift_en = 1'b1;
        st_d     = ST_LOW;
      end
      ST_PAUSE: if (done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // word result and status next values
  always_comb begin
    werr_d = shift_clr ? 1'b0 : (werr_q || any_err);
    vld_d  = done && !(werr_q || any_err);
    if (any_err)      err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
    else              err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b1;
      werr_q <= 1'b0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sclk_q <= sclk_d;
      werr_q <= werr_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (vld_d) data_q <= shreg;
  end

  assign sclk_o    = sclk_q;
  assign word_vld  = vld_q;
  assign word_data = data_q;
  assign err_flag  = err_q;

  AST_CLK_HIGH_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) || (st_q == ST_PAUSE)) |-> sclk_q); // R1
  AST_NO_START_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && !en) |=> sclk_q); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ((data_q >> len_eff) == '0)); // R4
  AST_CLEAN_WORD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> !$past(any_err)); // R8
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |=> err_q); // R5
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q); // R7
endmodule

// File: tb/tb_ssi_rx_master.sv
module tb_ssi_rx_master;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk, rst_n, en, sdata_i, err_clr;
  logic [5:0]  word_len;
  logic [15:0] half_div, dly_cyc;
  logic [31:0] pause_cyc, tmo_cyc;
  logic        sclk_o, word_vld, err_flag;
  logic [31:0] word_data;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  ssi_rx_master dut (
    .clk(clk), .rst_n(rst_n), .en(en), .word_len(word_len), .half_div(half_div),
    .pause_cyc(pause_cyc), .tmo_cyc(tmo_cyc), .dly_cyc(dly_cyc),
    .sdata_i(sdata_i), .err_clr(err_clr), .sclk_o(sclk_o),
    .word_vld(word_vld), .word_data(word_data), .err_flag(err_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; sdata_i = 1'b1; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input int h, input int len, input int p, input int t, input int d);
    half_div = 16'(h); word_len = 6'(len);
    pause_cyc = 32'(p); tmo_cyc = 32'(t); dly_cyc = 16'(d);
  endtask

  // sender model: answers the generated clock, then drives the gap pattern
  task automatic run_word(input logic [31:0] w, input int n, input int hi_lead,
                          input int low_len, input int p, input bit keep_en,
                          output logic [31:0] got, output int vld_k,
                          output int span, output int fall_k, output bit hi_ok);
    logic pv;
    int   bit_i;
    int   guard;
    bit   fin;
    got = '0; vld_k = -1; span = 0; fall_k = -1; hi_ok = 1'b1;
    en = 1'b1;
    guard = 0;
    pv = sclk_o;
    while (!(pv && !sclk_o) && guard < 1000) begin
      pv = sclk_o;
      @(negedge clk);
      guard++;
    end
    en = keep_en;
    bit_i = n - 1;
    pv = 1'b0;
    fin = 1'b0;
    while (!fin && span < 5000) begin
      @(negedge clk);
      span++;
      if (!pv && sclk_o) begin
        if (bit_i >= 0) begin
          sdata_i = w[bit_i];
          bit_i--;
        end else begin
          fin = 1'b1;
        end
      end
      pv = sclk_o;
    end
    for (int k = 0; k < p + 6; k++) begin
      sdata_i = (k < hi_lead) ? 1'b1 : (k < hi_lead + low_len) ? 1'b0 : 1'b1;
      @(negedge clk);
      if (word_vld && vld_k < 0) begin
        vld_k = k + 1;
        got   = word_data;
      end
      if (!sclk_o && fall_k < 0) fall_k = k + 1;
      if (k < p && !sclk_o) hi_ok = 1'b0;
    end
    sdata_i = 1'b1;
    en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(sclk_o === 1'b1, "R1", "clock after reset", 32'(sclk_o), 32'd1);
    check(word_vld === 1'b0, "R8", "valid after reset", 32'(word_vld), 32'd0);
    check(err_flag === 1'b0, "R7", "error after reset", 32'(err_flag), 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] g; int vk, sp, fk; bit hk;
    do_reset(); cfg(2, 8, 12, 6, 1);
    run_word(32'hA5, 8, 0, 8, 12, 1'b0, g, vk, sp, fk, hk);
    check(g === 32'hA5, "R2", "8-bit word", g, 32'hA5);
    check(sp == 34, "R3", "span H=2 N=8", 32'(sp), 32'd34);
    check(vk == 12, "R8", "valid delay", 32'(vk), 32'd12);
    check(hk, "R1", "clock high in pause", 32'(hk), 32'd1);
    check(err_flag === 1'b0, "R5", "clean word no error", 32'(err_flag), 32'd0);
  endtask

  task automatic t_long();
    logic [31:0] g; int vk, sp, fk; bit hk;
    do_reset(); cfg(1, 32, 10, 4, 0);
    run_word(32'hDEADBEEF, 32, 0, 5, 10, 1'b0, g, vk, sp, fk, hk);
    check(g === 32'hDEADBEEF, "R2", "32-bit word", g, 32'hDEADBEEF);
    check(sp == 65, "R3", "span H=1 N=32", 32'(sp), 32'd65);
  endtask

  task automatic t_short();
    logic [31:0] g; int vk, sp, fk; bit hk;
    do_reset(); cfg(3, 3, 8, 3, 0);
    run_word(32'hFFFFFFFF, 3, 0, 4, 8, 1'b0, g, vk, sp, fk, hk);
    check(g === 32'h7, "R4", "3-bit word upper zero", g, 32'h7);
    check(sp == 21, "R3", "span H=3 N=3", 32'(sp), 32'd21);
  endtask

  task automatic t_clamp();
    logic [31:0] g; int vk, sp, fk; bit hk;
    do_reset(); cfg(0, 1, 8, 3, 0);
    run_word(32'h5, 3, 0, 4, 8, 1'b0, g, vk, sp, fk, hk);
    check(g === 32'h5, "R2", "length 1 clamps to 3", g, 32'h5);
    check(sp == 7, "R3", "divider 0 acts as 1", 32'(sp), 32'd7);
    do_reset(); cfg(1, 45, 8, 3, 0);
    run_word(32'h80000001, 32, 0, 4, 8, 1'b0, g, vk, sp, fk, hk);
    check(g === 32'h80000001, "R2", "length 45 clamps to 32", g, 32'h80000001);
    check(sp == 65, "R2", "clamped span", 32'(sp), 32'd65);
  endtask

  task automatic t_delay_window();
    logic [31:0] g; int vk, sp, fk; bit hk;
    do_reset(); cfg(2, 10, 14, 8, 2);
    run_word(32'h2C9, 10, 4, 6, 14, 1'b0, g, vk, sp, fk, hk);
    check(err_flag === 1'b0, "R10", "high during guard", 32'(err_flag), 32'd0);
    check(vk == 14 && g === 32'h2C9, "R10", "word kept", g, 32'h2C9);
    do_reset(); cfg(2, 10, 14, 8, 2);
    run_word(32'h2C9, 10, 5, 5, 14, 1'b0, g, vk, sp, fk, hk);
    check(err_flag === 1'b1, "R5", "high one past guard", 32'(err_flag), 32'd1);
    check(vk < 0, "R8", "faulty word dropped", 32'(vk), 32'hFFFFFFFF);
  endtask

  task automatic t_early_high();
    logic [31:0] g; int vk, sp, fk; bit hk;
    do_reset(); cfg(1, 8, 10, 6, 0);
    run_word(32'h3C, 8, 0, 3, 10, 1'b0, g, vk, sp, fk, hk);
    check(err_flag === 1'b1, "R5", "released before timeout", 32'(err_flag), 32'd1);
    check(vk < 0, "R8", "early release dropped", 32'(vk), 32'hFFFFFFFF);
  endtask

  task automatic t_late_high();
    logic [31:0] g; int vk, sp, fk; bit hk;
    do_reset(); cfg(1, 8, 10, 4, 0);
    run_word(32'hC3, 8, 0, 9, 10, 1'b0, g, vk, sp, fk, hk);
    check(err_flag === 1'b0 && vk == 10, "R6", "high on last pause cycle ok", 32'(err_flag), 32'd0);
    do_reset(); cfg(1, 8, 10, 4, 0);
    run_word(32'hC3, 8, 0, 10, 10, 1'b0, g, vk, sp, fk, hk);
    check(err_flag === 1'b1, "R6", "low at pause end", 32'(err_flag), 32'd1);
    check(vk < 0, "R8", "late release dropped", 32'(vk), 32'hFFFFFFFF);
  endtask

  task automatic t_sticky();
    logic [31:0] g; int vk, sp, fk; bit hk;
    do_reset(); cfg(1, 8, 10, 4, 0);
    run_word(32'h11, 8, 0, 12, 10, 1'b0, g, vk, sp, fk, hk);
    run_word(32'h22, 8, 0, 5, 10, 1'b0, g, vk, sp, fk, hk);
    check(g === 32'h22 && vk == 10, "R8", "clean word after error", g, 32'h22);
    check(err_flag === 1'b1, "R7", "flag survives clean word", 32'(err_flag), 32'd1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    check(err_flag === 1'b0, "R7", "flag cleared", 32'(err_flag), 32'd0);
  endtask

  task automatic t_enable();
    logic [31:0] g; int vk, sp, fk; bit hk;
    int falls;
    do_reset(); cfg(1, 4, 9, 3, 0);
    falls = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!sclk_o) falls++;
    end
    check(falls == 0, "R9", "no start while disabled", 32'(falls), 32'd0);
    run_word(32'h9, 4, 0, 4, 9, 1'b1, g, vk, sp, fk, hk);
    check(fk == 10, "R9", "restart after pause", 32'(fk), 32'd10);
    check(hk, "R1", "clock high before restart", 32'(hk), 32'd1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_long();
    t_short();
    t_clamp();
    t_delay_window();
    t_early_high();
    t_late_high();
    t_sticky();
    t_enable();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule